// File: doc/BRIEF.md
# Fractional-Threshold Buffer Fullness Flags

This block watches the write and read pointers of a circular buffer and reports how close the buffer is to draining or overflowing. The buffer may be any size from 80 words upward, and its size need not be a power of two. Both pointers run from zero to one less than the buffer size and share one clock. All distances between them are taken modulo the buffer size. The flags therefore stay meaningful in a buffer that wraps around and overwrites its oldest data when full.

Each threshold is not a word count. It is a whole number of eightieths of the buffer size, one number for the empty side and one for the full side, and software supplies both as configuration inputs. The block also flags pointer equality every cycle.

A pulse on the jump input marks a run-time pointer set or clear. From then on the occupancy flags can no longer be trusted, so the block withdraws them and drops its validity indication. Only a reset restores them.

Top module: `ffg_flag_gen`

## Requirements
- R1: The empty threshold in words equals floor(DEPTH × ke / 80) and the full threshold equals floor(DEPTH × kf / 80), where ke and kf are the 7-bit unsigned configuration values.
- R2: While valid, almost_empty is high exactly when the lag (wr_ptr − rd_ptr) mod DEPTH is strictly less than the empty threshold.
- R3: While valid, almost_full is high exactly when the pointers differ and the lead (rd_ptr − wr_ptr) mod DEPTH is strictly less than DEPTH minus the full threshold. Equivalently, almost_full is high when the lag exceeds the full threshold.
- R4: collide is high exactly when wr_ptr equals rd_ptr, whether or not the flags are valid.
- R5: All four outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R6: A high ptr_jump drives flags_valid low from the next cycle. flags_valid then stays low until reset, and almost_empty and almost_full are held low for as long as it is low.
- R7: During and immediately after reset (rst_n low), almost_empty, almost_full and collide are 0 and flags_valid is 1.
- R8: A configuration value of 0 is treated as 1 and any value of 80 or more is treated as 79, so every threshold lies between 1/80 and 79/80 of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both pointers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr | input | AW | Write pointer, 0 to DEPTH−1 |
| rd_ptr | input | AW | Read pointer, 0 to DEPTH−1 |
| empty_k | input | 7 | Empty threshold in eightieths of DEPTH |
| full_k | input | 7 | Full threshold in eightieths of DEPTH |
| ptr_jump | input | 1 | Pulse marking a run-time pointer set or clear |
| almost_empty | output | 1 | Lag below the empty threshold |
| almost_full | output | 1 | Lag above the full threshold |
| collide | output | 1 | Pointers equal |
| flags_valid | output | 1 | Occupancy flags trustworthy |

## Verification
Several properties are checked on every cycle:
- collide follows pointer equality one cycle later.
- A jump clears validity, and validity never returns.
- The occupancy flags are silent while invalid.
- The empty and full flags rise whenever the internal lag crosses the thresholds the threshold units produce.
- Those thresholds stay inside the 1/80 to 79/80 band.

Some behaviour only the bench's scenarios can show:
- The exact floor rounding of the thresholds.
- The clamping of out-of-range configuration values.
- The off-by-one edges at lag equal to a threshold.
- Correct wrap-around arithmetic when the read pointer sits numerically above the write pointer.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

  localparam int K_BITS = 7;
  localparam int K_MIN  = 1;
  localparam int K_MAX  = 79;
  localparam int FRACS  = 80;

  function automatic int clamp_k(input int k);
    if (k < K_MIN) return K_MIN;
    if (k > K_MAX) return K_MAX;
    return k;
  endfunction

  function automatic int frac_words(input int depth, input int k);
    return (depth * clamp_k(k)) / FRACS;
  endfunction

  function automatic int mod_sub(input int a, input int b, input int depth);
    if (a >= b) return a - b;
    return a + depth - b;
  endfunction

endpackage

// File: rtl/ffg_threshold.sv
module ffg_threshold
  import ffg_pkg::*;
#(
  parameter int DEPTH = 1000,
  parameter int AW    = 10
) (
  input  logic [K_BITS-1:0] k_in,
  output logic [AW:0]       thr_words
);
  always_comb begin
    thr_words = (AW+1)'(frac_words(DEPTH, int'(k_in)));
  end
endmodule

// File: rtl/ffg_distance.sv
module ffg_distance
  import ffg_pkg::*;
#(
  parameter int DEPTH = 1000,
  parameter int AW    = 10
) (
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] lag,
  output logic [AW-1:0] lead,
  output logic          equal
);
  always_comb begin
    lag   = AW'(mod_sub(int'(wr_ptr), int'(rd_ptr), DEPTH));
    lead  = AW'(mod_sub(int'(rd_ptr), int'(wr_ptr), DEPTH));
    equal = (wr_ptr == rd_ptr);
  end
endmodule

// File: rtl/ffg_flag_reg.sv
module ffg_flag_reg #(
  parameter int DEPTH = 1000,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lag,
  input  logic [AW-1:0] lead,
  input  logic          equal,
  input  logic [AW:0]   thr_empty,
  input  logic [AW:0]   thr_full,
  input  logic          ptr_jump,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          collide,
  output logic          flags_valid
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic          valid_n;
  logic          ae_n;
  logic          af_n;
  logic [AW:0]   full_limit;

  always_comb begin
    full_limit = DEPTH_W - thr_full;
    valid_n    = flags_valid && !ptr_jump;
    ae_n       = valid_n && ({1'b0, lag} < thr_empty);
    af_n       = valid_n && !equal && ({1'b0, lead} < full_limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      almost_empty <= 1'b0;
      almost_full  <= 1'b0;
      collide      <= 1'b0;
      flags_valid  <= 1'b1;
    end else begin
      almost_empty <= ae_n;
      almost_full  <= af_n;
      collide      <= equal;
      flags_valid  <= valid_n;
    end
  end
endmodule

// File: rtl/ffg_flag_gen.sv
module ffg_flag_gen
  import ffg_pkg::*;
#(
  parameter int DEPTH = 1000,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     rd_ptr,
  input  logic [K_BITS-1:0] empty_k,
  input  logic [K_BITS-1:0] full_k,
  input  logic              ptr_jump,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              collide,
  output logic              flags_valid
);
  localparam int N_THR = 2;

  logic [K_BITS-1:0] k_sel [N_THR];
  logic [AW:0]       thr_w [N_THR];
  logic [AW:0]       thr_e_w;
  logic [AW:0]       thr_f_w;
  logic [AW-1:0]     lag_w;
  logic [AW-1:0]     lead_w;
  logic              equal_w;

  assign k_sel[0] = empty_k;
  assign k_sel[1] = full_k;
  assign thr_e_w  = thr_w[0];
  assign thr_f_w  = thr_w[1];

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    ffg_threshold #(.DEPTH(DEPTH), .AW(AW)) u_thr (
      .k_in      (k_sel[g]),
      .thr_words (thr_w[g])
    );
  end

  ffg_distance #(.DEPTH(DEPTH), .AW(AW)) u_dist (
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .lag    (lag_w),
    .lead   (lead_w),
    .equal  (equal_w)
  );

  ffg_flag_reg #(.DEPTH(DEPTH), .AW(AW)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .lag          (lag_w),
    .lead         (lead_w),
    .equal        (equal_w),
    .thr_empty    (thr_e_w),
    .thr_full     (thr_f_w),
    .ptr_jump     (ptr_jump),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .collide      (collide),
    .flags_valid  (flags_valid)
  );
endmodule

// File: rtl/ffg_checker.sv
module ffg_checker #(
  parameter int DEPTH = 1000,
  parameter int AW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          ptr_jump,
  input logic [AW-1:0] lag_w,
  input logic [AW:0]   thr_e_w,
  input logic [AW:0]   thr_f_w,
  input logic          almost_empty,
  input logic          almost_full,
  input logic          collide,
  input logic          flags_valid
);
  localparam logic [AW:0] THR_LO = (AW+1)'(DEPTH / 80);
  localparam logic [AW:0] THR_HI = (AW+1)'((DEPTH * 79) / 80);

  // R4
  collide_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == rd_ptr) |=> collide);
  // R4
  collide_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr != rd_ptr) |=> !collide);
  // R6
  jump_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_jump |=> !flags_valid);
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_valid |=> !flags_valid);
  // R6
  flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_valid |-> !(almost_empty || almost_full));
  // R2
  empty_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && !ptr_jump && ({1'b0, lag_w} < thr_e_w)) |=> almost_empty);
  // R3
  full_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && !ptr_jump && ({1'b0, lag_w} > thr_f_w)) |=> almost_full);
  // R8
  thr_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_e_w >= THR_LO) && (thr_e_w <= THR_HI) && (thr_f_w >= THR_LO) && (thr_f_w <= THR_HI));
endmodule

bind ffg_flag_gen ffg_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_ptr       (wr_ptr),
  .rd_ptr       (rd_ptr),
  .ptr_jump     (ptr_jump),
  .lag_w        (lag_w),
  .thr_e_w      (thr_e_w),
  .thr_f_w      (thr_f_w),
  .almost_empty (almost_empty),
  .almost_full  (almost_full),
  .collide      (collide),
  .flags_valid  (flags_valid)
);

// File: tb/ffg_flag_gen_bench.sv
module ffg_flag_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 1000;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] wr_ptr = '0;
  logic [AW-1:0] rd_ptr = '0;
  logic [6:0]    empty_k = 7'd8;
  logic [6:0]    full_k = 7'd72;
  logic          ptr_jump = 1'b0;
  logic          almost_empty, almost_full, collide, flags_valid;

  int checks = 0;
  int errors = 0;
  bit exp_valid = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ffg_flag_gen #(.DEPTH(D)) u_ffg_flag_gen (
    .clk, .rst_n, .wr_ptr, .rd_ptr, .empty_k, .full_k, .ptr_jump,
    .almost_empty, .almost_full, .collide, .flags_valid
  );

  function automatic int b_thr(input int k);
    int kc;
    kc = (k == 0) ? 1 : ((k >= 80) ? 79 : k);
    return (D * kc) / 80;
  endfunction

  function automatic int b_lag(input int w, input int r);
    return (w - r + D) % D;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int w, input int r, input int ke, input int kf, input bit jmp,
                      input string req);
    int lag;
    bit e_ae, e_af;
    wr_ptr = AW'(w); rd_ptr = AW'(r);
    empty_k = 7'(ke); full_k = 7'(kf); ptr_jump = jmp;
    lag = b_lag(w, r);
    if (jmp) exp_valid = 1'b0;
    e_ae = exp_valid && (lag < b_thr(ke));
    e_af = exp_valid && (lag > b_thr(kf));
    @(posedge clk); #1;
    check(req, "almost_empty", int'(almost_empty), int'(e_ae));
    check(req, "almost_full", int'(almost_full), int'(e_af));
    check("R4", "collide", int'(collide), int'(w == r));
    check("R6", "flags_valid", int'(flags_valid), int'(exp_valid));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wr_ptr = AW'(5); rd_ptr = AW'(5);
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state, equal pointers held in reset
    check("R7", "almost_empty", int'(almost_empty), 0);
    check("R7", "almost_full", int'(almost_full), 0);
    check("R7", "collide", int'(collide), 0);
    check("R7", "flags_valid", int'(flags_valid), 1);
    rst_n = 1'b1;

    // R5 registered: output changes only after the edge
    wr_ptr = AW'(40); rd_ptr = AW'(40);
    #2;
    check("R5", "collide before edge", int'(collide), 0);
    @(posedge clk); #1;
    check("R5", "collide after edge", int'(collide), 1);

    // R1/R2 empty edge, ke=8 -> 100 words, read numerically above write
    step(50, 951, 8, 72, 0, "R2");
    step(50, 950, 8, 72, 0, "R2");
    // R1/R3 full edge, kf=72 -> 900 words
    step(901, 0, 8, 72, 0, "R3");
    step(900, 0, 8, 72, 0, "R3");
    step(10, 109, 8, 72, 0, "R3");
    // R3 equality: lead 0 but pointers equal -> no almost_full
    step(777, 777, 8, 72, 0, "R3");
    // R8 clamping: k=0 -> 12 words, k=100 -> 987 words
    step(11, 0, 0, 100, 0, "R8");
    step(12, 0, 0, 100, 0, "R8");
    step(988, 0, 0, 100, 0, "R8");
    step(987, 0, 0, 100, 0, "R8");
    // R1 floor rounding: k=1 -> 12 words, k=79 -> 987 words
    step(999, 987, 1, 79, 0, "R1");
    step(999, 988, 1, 79, 0, "R1");

    for (int i = 0; i < 400; i++) begin
      step(int'($urandom % D), int'($urandom % D), int'($urandom % 128),
           int'($urandom % 128), 1'b0, "R2");
    end
    for (int i = 0; i < 50; i++) begin
      int w = int'($urandom % D);
      step(w, w, 40, 40, 1'b0, "R4");
    end

    // R6 jump, then flags held low and valid sticky
    step(5, 6, 8, 72, 1'b1, "R6");
    step(0, 1, 8, 72, 1'b0, "R6");
    step(950, 0, 8, 72, 1'b0, "R6");
    for (int i = 0; i < 30; i++) begin
      step(int'($urandom % D), int'($urandom % D), 40, 40, 1'b0, "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule